// File: doc/BRIEF.md
# Dual-channel synchronous serial port

The port moves words between a host-side register interface and two serial data lines, channel A and channel B. Both channels run from one shared serial clock input and one shared frame sync input. A single direction bit puts both channels in transmit or both in receive. In transmit mode, a word written by the host waits in a one-word buffer. It moves into a shift register on a word start and leaves most-significant-bit first. In receive mode, bits arriving on a channel's line gather in a shift register. The finished word is then placed in a one-word buffer for the host to read.

The serial clock is sampled by the system clock. A serial edge is a system clock edge at which `sclk` is high and was low at the previous system clock edge. Channel A can compress each outgoing word with a logarithmic (mu-law style) code before it is shifted. Channel B never alters data. An external slot-active input stands in for multichannel slot scheduling. Status flags report buffer fullness, buffer occupancy, and sticky underflow and overflow conditions.

Top module: `dual_serial_port`

## Requirements
- R1: Writing address 0 sets the control word: bit0 direction (1 = transmit), bit1 channel A enable, bit2 channel B enable, bit3 companding on A, bit4 framed mode, bit5 multichannel mode, bits 10:6 word length minus one (field values 0 and 1 give 3 bits). A control write clears both underflow and overflow sticky flags.
- R2: In transmit mode, a write to address 1 (A) or 2 (B) stores a word and sets that channel's `tx_full`. On the serial edge that starts a word, the word moves to the shift register, `tx_full` clears, and its top bit appears on `sd_out` right after that edge. In framed mode, a word starts on the serial edge that samples `fsync` high.
- R3: Word length runs from 3 to 32 bits. Only the low `len` bits of a word are sent, MSB first, one bit per serial edge. A received word holds exactly `len` bits, right-justified.
- R4: If a word starts while the transmit buffer is empty, the last word sent on that channel is sent again and that channel's `underflow` flag sets and stays set.
- R5: With companding on, channel A sends an 8-bit code right-justified in the word. The input is x = bits 12:0 as a signed value. mag = |x| capped at 4095. b = mag + 33. s = (index of the highest set bit of b) - 5. m = bits 3:0 of (b >> (s+1)). code = bitwise NOT of {sign of x, s[2:0], m}. Channel B is never companded.
- R6: In transmit mode with a channel enabled, `sd_oe` for that channel is 1 at all times. The exception is multichannel mode with `slot_active` low, where `sd_oe` is 0. In receive mode `sd_oe` is 0.
- R7: In receive mode, `sd_in` is sampled MSB first on serial edges, starting at the edge that samples `fsync` high when framed. After the last bit, the word goes to the channel's buffer and `rx_ready` sets. A read of address 3 (A) or 4 (B) returns it one cycle later with `rd_valid`, and `rx_ready` clears.
- R8: A word that completes while `rx_ready` is already set overwrites the buffer and sets the sticky `overflow` flag. This does not happen when a read of that buffer falls in the same cycle: the read returns the old word, the new word is kept, `rx_ready` stays 1, and no overflow is flagged.
- R9: The inactive direction ignores the serial clock and frame sync. A transmit buffer stays full through serial edges in receive mode. A receive buffer keeps its contents through serial edges in transmit mode.
- R10: In transmit mode, `rx_ready` reads 0. A read of address 3 or 4 returns `rd_err` = 1 with `rd_valid` = 0 and `rd_data` = 0.
- R11: A disabled channel ignores serial edges and has `sd_oe` = 0, independently of the other channel.
- R12: In unframed mode, a new word starts on the serial edge after the previous word's last bit, without frame sync.
- R13: After reset, `sd_oe`, `tx_full`, `rx_ready`, `underflow`, `overflow`, `rd_valid` and `rd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| fsync | input | 1 | Shared frame sync |
| slot_active | input | 1 | Current multichannel slot is active |
| sd_in | input | 2 | Serial data in, bit0 channel A, bit1 channel B |
| sd_out | output | 2 | Serial data out per channel |
| sd_oe | output | 2 | Output enable per channel |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | W | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| rd_data | output | W | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data is valid |
| rd_err | output | 1 | Receive buffer read attempted in transmit mode |
| tx_full | output | 2 | Transmit buffer holds a word, per channel |
| rx_ready | output | 2 | Receive buffer holds an unread word, per channel |
| underflow | output | 2 | Sticky transmit underflow, per channel |
| overflow | output | 2 | Sticky receive overflow, per channel |

## Verification
The host read of a receive buffer and the completion of a new word on the same channel can land on one system clock edge. The bench provokes this by raising the serial clock for a word's last bit in the same cycle that it strobes a read of that buffer. It then expects the read to return the earlier word, `rx_ready` to remain set, and `overflow` to stay clear. A second read must return the new word.

// File: rtl/dual_serial_port.sv
module dual_serial_port #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          fsync,
  input  logic          slot_active,
  input  logic [1:0]    sd_in,
  output logic [1:0]    sd_out,
  output logic [1:0]    sd_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          rd_err,
  output logic [1:0]    tx_full,
  output logic [1:0]    rx_ready,
  output logic [1:0]    underflow,
  output logic [1:0]    overflow
);
  localparam int LF = $clog2(W);
  localparam int CW = LF + 1;
  localparam int CTL_W = 6 + LF;

  logic [CTL_W-1:0] ctrl;
  logic             sclk_q;
  logic [W-1:0]     txbuf [2];
  logic [W-1:0]     txsh  [2];
  logic [W-1:0]     last  [2];
  logic [W-1:0]     rxbuf [2];
  logic [W-1:0]     rxsh  [2];
  logic [CW-1:0]    txcnt [2];
  logic [CW-1:0]    rxcnt [2];
  logic [1:0]       txf, rxne, unf, ovf;

  wire        dir    = ctrl[0];
  wire [1:0]  en     = ctrl[2:1];
  wire        cmp    = ctrl[3];
  wire        framed = ctrl[4];
  wire        mc     = ctrl[5];
  wire        tick   = sclk & ~sclk_q;
  wire [LF-1:0] lfld = ctrl[6 +: LF];
  wire [CW-1:0] wlen = (lfld < LF'(2)) ? CW'(3) : CW'(lfld) + CW'(1);
  wire [W-1:0]  mask = {W{1'b1}} >> (W - int'(wlen));

  function automatic logic [7:0] mulaw(input logic [12:0] x);
    logic [12:0] mag;
    logic [13:0] b;
    logic [2:0]  s;
    logic [3:0]  m;
    mag = x[12] ? (~x + 13'd1) : x;
    if (mag > 13'd4095) mag = 13'd4095;
    b = {1'b0, mag} + 14'd33;
    s = 3'd0;
    for (int i = 5; i < 13; i++) if (b[i]) s = 3'(i - 5);
    m = 4'(b >> (int'(s) + 1));
    return ~{x[12], s, m};
  endfunction

  logic [1:0]   tx_go, rx_go, txstart, txbusy, rxstart, rxbusy, rxdone, rdhit, wrhit;
  logic [W-1:0] src [2];
  logic [W-1:0] rxnext [2];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      tx_go[c]   = tick & dir & en[c];
      rx_go[c]   = tick & ~dir & en[c];
      txbusy[c]  = (txcnt[c] != '0) && (txcnt[c] < wlen);
      txstart[c] = framed ? fsync : ~txbusy[c];
      rxbusy[c]  = (rxcnt[c] != '0) && (rxcnt[c] < wlen);
      rxstart[c] = framed ? fsync : ~rxbusy[c];
      rxdone[c]  = rx_go[c] & ~rxstart[c] & rxbusy[c] & (rxcnt[c] + CW'(1) == wlen);
      rdhit[c]   = rd_en && (rd_addr == AW'(c + 3)) && !dir;
      wrhit[c]   = wr_en && (wr_addr == AW'(c + 1));
      rxnext[c]  = {rxsh[c][W-2:0], sd_in[c]};
      if (!txf[c])
        src[c] = last[c];
      else if (c == 0 && cmp)
        src[c] = {{(W-8){1'b0}}, mulaw(txbuf[0][12:0])};
      else
        src[c] = txbuf[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; sclk_q <= 1'b0;
      txf <= '0; rxne <= '0; unf <= '0; ovf <= '0;
      rd_data <= '0; rd_valid <= 1'b0; rd_err <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        txbuf[c] <= '0; txsh[c] <= '0; last[c] <= '0;
        rxbuf[c] <= '0; rxsh[c] <= '0; txcnt[c] <= '0; rxcnt[c] <= '0;
      end
    end else begin
      sclk_q   <= sclk;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
      if (wr_en && wr_addr == '0) begin
        ctrl <= wr_data[CTL_W-1:0];
        unf  <= '0;
        ovf  <= '0;
      end
      for (int c = 0; c < 2; c++) begin
        if (tx_go[c]) begin
          if (txstart[c]) begin
            txsh[c]  <= src[c] << (W - int'(wlen));
            last[c]  <= src[c];
            txcnt[c] <= CW'(1);
            if (txf[c]) txf[c] <= 1'b0;
            else        unf[c] <= 1'b1;
          end else if (txbusy[c]) begin
            txsh[c]  <= txsh[c] << 1;
            txcnt[c] <= txcnt[c] + CW'(1);
          end
        end
        if (wrhit[c]) begin
          txbuf[c] <= wr_data;
          txf[c]   <= 1'b1;
        end
        if (rdhit[c]) rxne[c] <= 1'b0;
        if (rx_go[c] && (rxstart[c] || rxbusy[c])) begin
          rxsh[c]  <= rxnext[c];
          rxcnt[c] <= rxstart[c] ? CW'(1) : rxcnt[c] + CW'(1);
        end
        if (rxdone[c]) begin
          rxbuf[c] <= rxnext[c] & mask;
          rxne[c]  <= 1'b1;
          if (rxne[c] && !rdhit[c]) ovf[c] <= 1'b1;
        end
      end
      if (rd_en) begin
        if (rd_addr == AW'(3) || rd_addr == AW'(4)) begin
          if (dir) rd_err <= 1'b1;
          else begin
            rd_valid <= 1'b1;
            rd_data  <= rxbuf[(rd_addr == AW'(4)) ? 1 : 0];
          end
        end else begin
          rd_valid <= 1'b1;
          if (rd_addr == '0) rd_data <= W'(ctrl);
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      sd_out[c] = txsh[c][W-1];
      sd_oe[c]  = dir & en[c] & (~mc | slot_active);
    end
  end
  assign tx_full   = txf;
  assign rx_ready  = rxne & {2{~dir}};
  assign underflow = unf;
  assign overflow  = ovf;

  a_r9_rx_frozen_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    dir |=> $stable(rxcnt[0]));
  a_r2_full_clears_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go[0] && txstart[0] && txf[0] && !wrhit[0]) |=> !txf[0]);
  a_r4_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf[0]) |-> $past(!txf[0]));
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[1]) |-> $past(rxne[1]));
  a_r10_read_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_err));
endmodule

// File: tb/tb_dual_serial_port.sv
module tb_dual_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, fsync = 1'b0, slot_active = 1'b0;
  logic [1:0] sd_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] sd_out, sd_oe, tx_full, rx_ready, underflow, overflow;
  logic [31:0] rd_data;
  logic rd_valid, rd_err;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dual_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .slot_active(slot_active),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err), .tx_full(tx_full), .rx_ready(rx_ready),
    .underflow(underflow), .overflow(overflow));

  // len, compand, data, expected channel A word
  localparam logic [70:0] VEC [9] = '{
    {6'd8,  1'b0, 32'h000000A5, 32'h000000A5},
    {6'd32, 1'b0, 32'hDEADBEEF, 32'hDEADBEEF},
    {6'd3,  1'b0, 32'h00000005, 32'h00000005},
    {6'd12, 1'b0, 32'h0000FABC, 32'h00000ABC},
    {6'd8,  1'b1, 32'h00000000, 32'h000000FF},
    {6'd8,  1'b1, 32'h0000012C, 32'h000000CB},
    {6'd8,  1'b1, 32'h00001FFF, 32'h0000007E},
    {6'd16, 1'b1, 32'h00000064, 32'h000000DF},
    {6'd8,  1'b1, 32'h00000FFF, 32'h0000008F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit d, input bit ea, input bit eb, input bit c,
                                     input bit f, input bit m, input int len);
    return 32'(d) | (32'(ea) << 1) | (32'(eb) << 2) | (32'(c) << 3) | (32'(f) << 4)
         | (32'(m) << 5) | (32'(len - 1) << 6);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic sedge(input bit fs, input bit ba, input bit bb);
    @(negedge clk); sclk = 1'b1; fsync = fs; sd_in = {bb, ba};
    @(negedge clk); sclk = 1'b0; fsync = 1'b0;
  endtask

  task automatic txword(input int len, input bit framed, output logic [31:0] a, output logic [31:0] b);
    a = '0; b = '0;
    for (int i = 0; i < len; i++) begin
      sedge(framed && i == 0, 1'b1, 1'b1);
      a = {a[30:0], sd_out[0]};
      b = {b[30:0], sd_out[1]};
    end
  endtask

  task automatic rxword(input int len, input logic [31:0] wa, input logic [31:0] wb);
    for (int i = 0; i < len; i++) sedge(i == 0, wa[len-1-i], wb[len-1-i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] ga, gb;
    repeat (3) @(negedge clk);
    chk("R13 sd_oe", 32'(sd_oe), 0);
    chk("R13 flags", {tx_full, rx_ready, underflow, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 read flags", {rd_valid, rd_err}, 0);

    for (int v = 0; v < 9; v++) begin
      int len;
      logic [31:0] d, m;
      len = int'(VEC[v][70:65]);
      d = VEC[v][63:32];
      m = (len == 32) ? 32'hFFFFFFFF : ((32'd1 << len) - 1);
      wr(3'd0, mk(1, 1, 1, VEC[v][64], 1, 0, len));
      wr(3'd1, d);
      wr(3'd2, d);
      txword(len, 1, ga, gb);
      chk(VEC[v][64] ? "R5 channel A companded" : "R3 channel A word", ga, VEC[v][31:0]);
      chk("R5 channel B plain", gb, d & m);
    end

    wr(3'd0, mk(1, 1, 0, 0, 1, 0, 8));
    wr(3'd1, 32'hC3);
    wr(3'd2, 32'h55);
    chk("R2 full after write", 32'(tx_full), 2'b11);
    sedge(1, 0, 0);
    chk("R2 full clears on load", 32'(tx_full[0]), 0);
    chk("R2 first bit at frame edge", 32'(sd_out[0]), 1);
    for (int i = 1; i < 8; i++) sedge(0, 0, 0);
    txword(8, 1, ga, gb);
    chk("R4 resend last word", ga, 32'hC3);
    chk("R4 underflow sticky", 32'(underflow), 2'b01);
    chk("R11 disabled channel keeps buffer", 32'(tx_full[1]), 1);
    chk("R11 disabled channel not driven", 32'(sd_oe[1]), 0);
    wr(3'd0, mk(1, 1, 0, 0, 1, 0, 8));
    chk("R1 control write clears underflow", 32'(underflow), 0);
    rd(3'd0);
    chk("R1 control readback", rd_data, mk(1, 1, 0, 0, 1, 0, 8));

    wr(3'd0, mk(1, 1, 0, 0, 1, 1, 8));
    slot_active = 1'b0; #1;
    chk("R6 inactive slot releases", 32'(sd_oe[0]), 0);
    slot_active = 1'b1; #1;
    chk("R6 active slot drives", 32'(sd_oe[0]), 1);
    wr(3'd0, mk(1, 1, 0, 0, 1, 0, 8));
    slot_active = 1'b0; #1;
    chk("R6 driven outside multichannel", 32'(sd_oe[0]), 1);

    wr(3'd0, mk(1, 1, 0, 0, 0, 0, 4));
    wr(3'd1, 32'h9);
    sedge(0, 0, 0);
    ga = {31'b0, sd_out[0]};
    wr(3'd1, 32'h6);
    for (int i = 1; i < 8; i++) begin
      sedge(0, 0, 0);
      ga = {ga[30:0], sd_out[0]};
    end
    chk("R12 back-to-back words", ga, 32'h96);
    chk("R12 no underflow", 32'(underflow[0]), 0);

    wr(3'd0, mk(0, 1, 1, 0, 1, 0, 8));
    chk("R6 receive mode not driven", 32'(sd_oe), 0);
    rxword(8, 32'hA7, 32'h1E);
    chk("R7 ready both", 32'(rx_ready), 2'b11);
    rd(3'd3);
    chk("R7 read A", {rd_valid, rd_data[30:0]}, {1'b1, 31'hA7});
    chk("R7 ready clears", 32'(rx_ready[0]), 0);
    rd(3'd4);
    chk("R7 read B", rd_data, 32'h1E);

    wr(3'd0, mk(0, 1, 0, 0, 1, 0, 8));
    rxword(8, 32'h11, 0);
    rxword(8, 32'h22, 0);
    chk("R8 overflow sticky", 32'(overflow[0]), 1);
    rd(3'd3);
    chk("R8 newest word kept", rd_data, 32'h22);

    wr(3'd0, mk(0, 1, 0, 0, 1, 0, 8));
    rxword(8, 32'h33, 0);
    for (int i = 0; i < 7; i++) sedge(i == 0, 1'(8'h44 >> (7 - i)), 0);
    @(negedge clk); sclk = 1'b1; sd_in = 2'b00; rd_en = 1'b1; rd_addr = 3'd3;
    @(negedge clk); sclk = 1'b0; rd_en = 1'b0;
    chk("R8 same-cycle read old word", rd_data, 32'h33);
    chk("R8 same-cycle ready kept", 32'(rx_ready[0]), 1);
    chk("R8 same-cycle no overflow", 32'(overflow[0]), 0);
    rd(3'd3);
    chk("R8 same-cycle new word", rd_data, 32'h44);

    rxword(8, 32'h5A, 0);
    wr(3'd1, 32'h77);
    for (int i = 0; i < 4; i++) sedge(1, 1, 1);
    chk("R9 tx buffer idle in receive", 32'(tx_full[0]), 1);
    wr(3'd0, mk(1, 1, 0, 0, 1, 0, 8));
    chk("R10 ready reads empty", 32'(rx_ready), 0);
    rd(3'd3);
    chk("R10 read error", {rd_err, rd_valid, rd_data[29:0]}, 32'h80000000);
    txword(8, 1, ga, gb);
    chk("R9 tx word after receive", ga, 32'h77);
    wr(3'd0, mk(0, 1, 0, 0, 1, 0, 8));
    chk("R9 rx buffer kept", 32'(rx_ready[0]), 1);
    rd(3'd3);
    chk("R9 rx word unchanged", rd_data, 32'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule